// File: doc/BRIEF.md
# Block Store Completion Tracker

This block follows store arrivals for up to eight in-flight atomic instruction blocks. Memory operations are spread over four address-interleaved memory tiles. Each tile accepts the stores that land on it and sends every accepted store, as a frame number and an ordering ID, around a ring of broadcast links. Each tile therefore ends up with its own copy of the per-frame record of arrived stores. The model contains all four tiles and the links between them.

Each instruction in a block carries a 5-bit ordering ID. The block header states how many stores the block produces and which ordering IDs are stores. A block is complete when the number of distinct arrived store IDs equals the header count. Each tile detects completion from its own view. Only tile 0 reports it outward, as a one-cycle pulse. Each tile also publishes, for every frame, a wake prefix: the number of leading ordering IDs that need no further wait. A deferred load with ordering ID L may wake once that prefix is at least L. Loads that sit between the same two stores therefore become eligible together and may be woken in any order.

Each tile has one store input stream with a valid/ready handshake. A tile holds back-pressure only in a cycle where a clear is issued for the same frame. The sender must then keep valid, frame and ID steady until ready returns. Header load and frame clear are plain control pulses.

Top module: `store_track_top`

## Requirements
- R1: A store accepted by tile t at clock edge E is reflected in tile t's state right after E. It reaches tiles t+1 and t-1 (mod 4) after edge E+1, and tile t+2 (mod 4) after edge E+2.
- R2: `st_ready[t]` is low exactly when `clr_valid` is high and `clr_frame` equals that tile's `st_frame`. A store offered while ready is low is not accepted, and it is taken on a later cycle once ready is high.
- R3: Store IDs are recorded as a set. A repeated arrival of an ID already recorded in a frame does not change that frame's count.
- R4: A tile regards a frame as complete (`frame_view` bit tile*8+frame) once a header has been loaded for it and the count of distinct arrived IDs equals `hdr_count`. `done_valid` with `done_frame` is raised in the first cycle in which tile 0's view becomes complete.
- R5: `done_valid` is raised for a given frame in exactly one cycle between two clears of that frame. Later duplicate arrivals do not raise it again.
- R6: When several frames are complete but not yet reported in tile 0's view, they are reported one per cycle, lowest frame number first.
- R7: The wake prefix of frame f at tile t is `wake_prefix[(t*8+f)*6 +: 6]`. It is 0 until a header is loaded for the frame. After that it is the length of the longest run, starting at ID 0, of IDs that have either arrived or are not stores in `hdr_smask` (bit i set means ID i is a store). Its range is 0 to 32.
- R8: A clear of frame f at edge E empties f's record, header and report flag in all tiles at E. Any store for f still travelling on the links at E is dropped.
- R9: A header with count 0 completes the frame in the cycle right after the header edge.
- R10: After reset all wake prefixes are 0, `done_valid` is low and every `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 4 | Per-tile store offer |
| st_ready | output | 4 | Per-tile store accept |
| st_frame | input | 12 | Per-tile store frame, 3 bits per tile |
| st_lsid | input | 20 | Per-tile store ordering ID, 5 bits per tile |
| hdr_valid | input | 1 | Header load pulse |
| hdr_frame | input | 3 | Frame of the header |
| hdr_count | input | 6 | Expected number of stores (0 to 32) |
| hdr_smask | input | 32 | Which ordering IDs are stores |
| clr_valid | input | 1 | Frame commit/flush pulse |
| clr_frame | input | 3 | Frame to clear |
| done_valid | output | 1 | Block completion pulse from tile 0 |
| done_frame | output | 3 | Frame that completed |
| wake_prefix | output | 192 | Per tile, per frame wake prefix, 6 bits each |
| frame_view | output | 32 | Per tile, per frame local completion view |

## Verification
The hardest case to reach is a store that is still on the links when its frame is cleared. A leaked stray bit would corrupt the frame's next life. The stimulus sends a store from the tile two hops from tile 0 and issues the clear on the very next edge, while the message sits in its first and second hop stages. It then reloads the frame with a header whose first ID is a store and checks that no tile's wake prefix moves off zero. Simultaneous completions are produced by sending the last stores of two frames from the two tiles at equal distance from tile 0 on the same edge.

// File: rtl/stc_pkg.sv
package stc_pkg;
  localparam int unsigned TILES = 4;
  // message source slots seen by each tile
  localparam int unsigned SRC_OWN   = 0;
  localparam int unsigned SRC_LEFT  = 1;
  localparam int unsigned SRC_RIGHT = 2;
  localparam int unsigned SRC_FAR   = 3;
  localparam int unsigned SRCS      = 4;
endpackage

// File: rtl/stc_link.sv
module stc_link #(
  parameter int unsigned FW = 3,
  parameter int unsigned LW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          acc,
  input  logic [FW-1:0] frame,
  input  logic [LW-1:0] lsid,
  input  logic          clr_valid,
  input  logic [FW-1:0] clr_frame,
  output logic          h1_v,
  output logic [FW-1:0] h1_f,
  output logic [LW-1:0] h1_id,
  output logic          h2_v,
  output logic [FW-1:0] h2_f,
  output logic [LW-1:0] h2_id
);
  // first hop reaches both ring neighbours, second hop the opposite tile
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      h1_v <= 1'b0;
      h2_v <= 1'b0;
    end else begin
      h1_v <= acc && !(clr_valid && clr_frame == frame);
      h2_v <= h1_v && !(clr_valid && clr_frame == h1_f);
    end
    h1_f  <= frame;
    h1_id <= lsid;
    h2_f  <= h1_f;
    h2_id <= h1_id;
  end

  a_r1_far_after_near: assert property (@(posedge clk) disable iff (!rst_n)
    h2_v |-> $past(h1_v));
  a_r8_drop_in_flight: assert property (@(posedge clk) disable iff (!rst_n)
    (h1_v && clr_valid && clr_frame == h1_f) |=> !h2_v);
endmodule

// File: rtl/stc_tile.sv
module stc_tile
  import stc_pkg::*;
#(
  parameter int unsigned NF  = 8,
  parameter int unsigned FW  = 3,
  parameter int unsigned LW  = 5,
  parameter int unsigned IDN = 32,
  parameter int unsigned CW  = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [SRCS-1:0] in_v,
  input  logic [FW-1:0]   in_f  [SRCS],
  input  logic [LW-1:0]   in_id [SRCS],
  input  logic            hdr_valid,
  input  logic [FW-1:0]   hdr_frame,
  input  logic [CW-1:0]   hdr_count,
  input  logic [IDN-1:0]  hdr_smask,
  input  logic            clr_valid,
  input  logic [FW-1:0]   clr_frame,
  output logic [NF*CW-1:0] prefix,
  output logic [NF-1:0]    cmpl
);
  logic [IDN-1:0] bmap_q  [NF];
  logic [IDN-1:0] smask_q [NF];
  logic [CW-1:0]  exp_q   [NF];
  logic [NF-1:0]  hv_q;
  logic [IDN-1:0] set_b   [NF];

  function automatic logic [CW-1:0] ones_of(input logic [IDN-1:0] b);
    logic [CW-1:0] n;
    n = '0;
    for (int i = 0; i < IDN; i++) n = n + CW'(b[i]);
    return n;
  endfunction

  function automatic logic [CW-1:0] run_of(input logic [IDN-1:0] b);
    logic [CW-1:0] n;
    logic go;
    n  = '0;
    go = 1'b1;
    for (int i = 0; i < IDN; i++) begin
      go = go & b[i];
      n  = n + CW'(go);
    end
    return n;
  endfunction

  always_comb begin
    for (int f = 0; f < NF; f++) begin
      set_b[f] = '0;
      for (int s = 0; s < SRCS; s++)
        if (in_v[s] && in_f[s] == FW'(f)) set_b[f][in_id[s]] = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hv_q <= '0;
      for (int f = 0; f < NF; f++) begin
        bmap_q[f]  <= '0;
        smask_q[f] <= '0;
        exp_q[f]   <= '0;
      end
    end else begin
      for (int f = 0; f < NF; f++) begin
        if (clr_valid && clr_frame == FW'(f)) begin
          bmap_q[f]  <= '0;
          smask_q[f] <= '0;
          exp_q[f]   <= '0;
          hv_q[f]    <= 1'b0;
        end else begin
          bmap_q[f] <= bmap_q[f] | set_b[f];
          if (hdr_valid && hdr_frame == FW'(f)) begin
            hv_q[f]    <= 1'b1;
            exp_q[f]   <= hdr_count;
            smask_q[f] <= hdr_smask;
          end
        end
      end
    end
  end

  for (genvar f = 0; f < NF; f++) begin : g_frame
    assign cmpl[f] = hv_q[f] && (ones_of(bmap_q[f]) == exp_q[f]);
    assign prefix[f*CW +: CW] = hv_q[f] ? run_of(bmap_q[f] | ~smask_q[f]) : '0;

    a_r3_bits_only_grow: assert property (@(posedge clk) disable iff (!rst_n)
      !(clr_valid && clr_frame == FW'(f)) |=> ((bmap_q[f] & $past(bmap_q[f])) == $past(bmap_q[f])));
    a_r8_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_valid && clr_frame == FW'(f)) |=> (bmap_q[f] == '0 && prefix[f*CW +: CW] == '0));
  end
endmodule

// File: rtl/stc_done_pick.sv
module stc_done_pick #(
  parameter int unsigned NF = 8,
  parameter int unsigned FW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] cmpl,
  input  logic          clr_valid,
  input  logic [FW-1:0] clr_frame,
  output logic          done_valid,
  output logic [FW-1:0] done_frame
);
  logic [NF-1:0] sent_q;
  logic [NF-1:0] cand;

  assign cand       = cmpl & ~sent_q;
  assign done_valid = |cand;

  always_comb begin
    done_frame = '0;
    for (int f = NF - 1; f >= 0; f--)
      if (cand[f]) done_frame = FW'(f);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sent_q <= '0;
    end else begin
      for (int f = 0; f < NF; f++) begin
        if (clr_valid && clr_frame == FW'(f)) sent_q[f] <= 1'b0;
        else if (done_valid && done_frame == FW'(f)) sent_q[f] <= 1'b1;
      end
    end
  end

  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (done_valid && !(clr_valid && clr_frame == done_frame)) |=>
      !(done_valid && done_frame == $past(done_frame)));
  a_r6_backlog_drains: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(cand) > 1 && !clr_valid) |=> done_valid);
endmodule

// File: rtl/store_track_top.sv
module store_track_top
  import stc_pkg::*;
#(
  parameter int unsigned NUM_FRAMES = 8,
  parameter int unsigned LSID_W     = 5,
  localparam int unsigned FW  = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1,
  localparam int unsigned IDN = 1 << LSID_W,
  localparam int unsigned CW  = LSID_W + 1
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [TILES-1:0]              st_valid,
  output logic [TILES-1:0]              st_ready,
  input  logic [TILES*FW-1:0]           st_frame,
  input  logic [TILES*LSID_W-1:0]       st_lsid,
  input  logic                          hdr_valid,
  input  logic [FW-1:0]                 hdr_frame,
  input  logic [CW-1:0]                 hdr_count,
  input  logic [IDN-1:0]                hdr_smask,
  input  logic                          clr_valid,
  input  logic [FW-1:0]                 clr_frame,
  output logic                          done_valid,
  output logic [FW-1:0]                 done_frame,
  output logic [TILES*NUM_FRAMES*CW-1:0] wake_prefix,
  output logic [TILES*NUM_FRAMES-1:0]   frame_view
);
  logic [TILES-1:0]  acc;
  logic [TILES-1:0]  h1_v, h2_v;
  logic [FW-1:0]     h1_f  [TILES];
  logic [FW-1:0]     h2_f  [TILES];
  logic [LSID_W-1:0] h1_id [TILES];
  logic [LSID_W-1:0] h2_id [TILES];
  logic [SRCS-1:0]   tv    [TILES];
  logic [FW-1:0]     tf    [TILES][SRCS];
  logic [LSID_W-1:0] tid   [TILES][SRCS];

  for (genvar t = 0; t < TILES; t++) begin : g_tile
    localparam int unsigned LT = (t + TILES - 1) % TILES;
    localparam int unsigned RT = (t + 1) % TILES;
    localparam int unsigned FT = (t + 2) % TILES;

    assign st_ready[t] = !(clr_valid && clr_frame == st_frame[t*FW +: FW]);
    assign acc[t]      = st_valid[t] && st_ready[t];

    stc_link #(.FW(FW), .LW(LSID_W)) u_link (
      .clk(clk), .rst_n(rst_n), .acc(acc[t]),
      .frame(st_frame[t*FW +: FW]), .lsid(st_lsid[t*LSID_W +: LSID_W]),
      .clr_valid(clr_valid), .clr_frame(clr_frame),
      .h1_v(h1_v[t]), .h1_f(h1_f[t]), .h1_id(h1_id[t]),
      .h2_v(h2_v[t]), .h2_f(h2_f[t]), .h2_id(h2_id[t])
    );

    assign tv[t][SRC_OWN]    = acc[t];
    assign tf[t][SRC_OWN]    = st_frame[t*FW +: FW];
    assign tid[t][SRC_OWN]   = st_lsid[t*LSID_W +: LSID_W];
    assign tv[t][SRC_LEFT]   = h1_v[LT];
    assign tf[t][SRC_LEFT]   = h1_f[LT];
    assign tid[t][SRC_LEFT]  = h1_id[LT];
    assign tv[t][SRC_RIGHT]  = h1_v[RT];
    assign tf[t][SRC_RIGHT]  = h1_f[RT];
    assign tid[t][SRC_RIGHT] = h1_id[RT];
    assign tv[t][SRC_FAR]    = h2_v[FT];
    assign tf[t][SRC_FAR]    = h2_f[FT];
    assign tid[t][SRC_FAR]   = h2_id[FT];

    stc_tile #(.NF(NUM_FRAMES), .FW(FW), .LW(LSID_W), .IDN(IDN), .CW(CW)) u_tile (
      .clk(clk), .rst_n(rst_n),
      .in_v(tv[t]), .in_f(tf[t]), .in_id(tid[t]),
      .hdr_valid(hdr_valid), .hdr_frame(hdr_frame),
      .hdr_count(hdr_count), .hdr_smask(hdr_smask),
      .clr_valid(clr_valid), .clr_frame(clr_frame),
      .prefix(wake_prefix[t*NUM_FRAMES*CW +: NUM_FRAMES*CW]),
      .cmpl(frame_view[t*NUM_FRAMES +: NUM_FRAMES])
    );
  end

  // completion leaves the block only through tile 0's view
  stc_done_pick #(.NF(NUM_FRAMES), .FW(FW)) u_pick (
    .clk(clk), .rst_n(rst_n), .cmpl(frame_view[NUM_FRAMES-1:0]),
    .clr_valid(clr_valid), .clr_frame(clr_frame),
    .done_valid(done_valid), .done_frame(done_frame)
  );

  a_r9_header_count_range: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_valid |-> hdr_count <= CW'(IDN));
  a_r2_stalled_store_held: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid[0] && !st_ready[0]) |=> st_valid[0]);
endmodule

// File: tb/tb_store_track_top.sv
module tb_store_track_top;
  localparam int NT = 4;
  localparam int NF = 8;
  localparam int FW = 3;
  localparam int LW = 5;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NT-1:0]     st_valid = '0;
  logic [NT-1:0]     st_ready;
  logic [NT*FW-1:0]  st_frame = '0;
  logic [NT*LW-1:0]  st_lsid = '0;
  logic              hdr_valid = 1'b0;
  logic [FW-1:0]     hdr_frame = '0;
  logic [CW-1:0]     hdr_count = '0;
  logic [31:0]       hdr_smask = '0;
  logic              clr_valid = 1'b0;
  logic [FW-1:0]     clr_frame = '0;
  logic              done_valid;
  logic [FW-1:0]     done_frame;
  logic [NT*NF*CW-1:0] wake_prefix;
  logic [NT*NF-1:0]  frame_view;

  store_track_top dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_frame(st_frame), .st_lsid(st_lsid), .hdr_valid(hdr_valid),
    .hdr_frame(hdr_frame), .hdr_count(hdr_count), .hdr_smask(hdr_smask),
    .clr_valid(clr_valid), .clr_frame(clr_frame), .done_valid(done_valid),
    .done_frame(done_frame), .wake_prefix(wake_prefix), .frame_view(frame_view)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit finished = 1'b0;

  typedef struct { int fr; int cy; } done_t;
  done_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int pf(input int t, input int f);
    return int'(wake_prefix[(t*NF+f)*CW +: CW]);
  endfunction

  // scoreboard monitor: every pulse must match the next expected item
  always @(negedge clk) begin
    if (rst_n && done_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R5 actual done frame %0d at cycle %0d expected no pulse", done_frame, cyc);
      end else begin
        done_t e;
        e = exp_q.pop_front();
        if (int'(done_frame) != e.fr || cyc != e.cy) begin
          errors++;
          $display("FAIL R4/R6 actual frame %0d cycle %0d expected frame %0d cycle %0d",
                   done_frame, cyc, e.fr, e.cy);
        end
      end
    end
  end

  task automatic expect_done(input int f, input int at);
    done_t e;
    e.fr = f;
    e.cy = at;
    exp_q.push_back(e);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put_store(input int t, input int f, input int id);
    st_valid[t] = 1'b1;
    st_frame[t*FW +: FW] = FW'(f);
    st_lsid[t*LW +: LW] = LW'(id);
  endtask

  task automatic send_store(input int t, input int f, input int id);
    put_store(t, f, id);
    tick();
    st_valid = '0;
  endtask

  task automatic send_hdr(input int f, input int cnt, input logic [31:0] m);
    hdr_valid = 1'b1;
    hdr_frame = FW'(f);
    hdr_count = CW'(cnt);
    hdr_smask = m;
    tick();
    hdr_valid = 1'b0;
  endtask

  task automatic send_clr(input int f);
    clr_valid = 1'b1;
    clr_frame = FW'(f);
    tick();
    clr_valid = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R10 reset state
    check("R10 ready", int'(st_ready), 15);
    check("R10 done", int'(done_valid), 0);
    check("R10 prefix", int'(wake_prefix == '0), 1);

    // R9 zero-count header completes right after the header edge
    expect_done(1, cyc + 1);
    send_hdr(1, 0, 32'h0);
    tick();

    // R1 R7 spread timing and prefix; stores at IDs 0,2,5
    send_hdr(2, 3, 32'h0000_0025);
    for (int t = 0; t < NT; t++) check("R7 prefix before stores", pf(t, 2), 0);
    send_store(2, 2, 0);
    check("R1 origin tile2", pf(2, 2), 2);
    check("R1 tile1 not yet", pf(1, 2), 0);
    check("R1 tile0 not yet", pf(0, 2), 0);
    tick();
    check("R1 neighbour tile1", pf(1, 2), 2);
    check("R1 neighbour tile3", pf(3, 2), 2);
    check("R1 far tile0 not yet", pf(0, 2), 0);
    tick();
    check("R1 far tile0", pf(0, 2), 2);

    // R3 duplicate of ID 0 must not count
    send_store(0, 2, 0);
    send_store(1, 2, 2);
    repeat (3) tick();
    check("R3 no early completion view", int'(frame_view[2]), 0);
    check("R7 prefix run to ID 5", pf(0, 2), 5);
    expect_done(2, cyc + 2);
    send_store(3, 2, 5);
    repeat (3) tick();
    for (int t = 0; t < NT; t++) check("R7 full prefix", pf(t, 2), 32);
    for (int t = 0; t < NT; t++) check("R4 tile view", int'(frame_view[t*NF+2]), 1);

    // R5 late duplicate raises no second pulse
    send_store(2, 2, 2);
    repeat (4) tick();
    check("R5 no pending pulse", exp_q.size(), 0);

    // R6 two frames complete in one cycle at tile 0
    send_hdr(3, 1, 32'h1);
    send_hdr(4, 1, 32'h1);
    expect_done(3, cyc + 2);
    expect_done(4, cyc + 3);
    put_store(1, 4, 0);
    put_store(3, 3, 0);
    tick();
    st_valid = '0;
    repeat (4) tick();

    // R8 clear empties every tile
    send_clr(2);
    for (int t = 0; t < NT; t++) check("R8 cleared prefix", pf(t, 2), 0);
    check("R8 cleared view", int'(frame_view[2]), 0);

    // R8 in-flight store dropped by a clear on the next edge
    send_hdr(5, 2, 32'h3);
    send_store(2, 5, 0);
    send_clr(5);
    repeat (3) tick();
    send_hdr(5, 2, 32'h3);
    repeat (3) tick();
    for (int t = 0; t < NT; t++) check("R8 no stale bit", pf(t, 5), 0);
    send_store(0, 5, 1);
    expect_done(5, cyc + 1);
    send_store(0, 5, 0);
    repeat (3) tick();

    // R2 back-pressure only on a same-frame clear
    clr_valid = 1'b1;
    clr_frame = 3'd6;
    put_store(1, 6, 0);
    put_store(0, 7, 0);
    #1;
    check("R2 stalled tile1", int'(st_ready[1]), 0);
    check("R2 other tile ready", int'(st_ready[0]), 1);
    st_valid[0] = 1'b0;
    tick();
    clr_valid = 1'b0;
    #1;
    check("R2 ready after clear", int'(st_ready[1]), 1);
    tick();
    st_valid = '0;
    repeat (3) tick();
    for (int t = 0; t < NT; t++) check("R2 no header no prefix", pf(t, 6), 0);
    expect_done(6, cyc + 1);
    send_hdr(6, 1, 32'h1);
    for (int t = 0; t < NT; t++) check("R2 held store recorded", pf(t, 6), 32);
    repeat (3) tick();

    check("R4 all expected pulses seen", exp_q.size(), 0);
    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule